// File: doc/BRIEF.md
# Buffered Serial Data Port

This block sits between a processor bus and a serial line engine. The processor sees one data register. Reading it takes the oldest received byte from a receive queue. Writing it appends a byte to a transmit queue. Each queue is a circular byte store, tracked by an insert index and a fill count. The default depth is 256 entries. A status byte reports whether received data is waiting, whether the transmit queue has room, and whether a received byte was lost. The interrupt line is the OR of the status flags that the interrupt mask enables.

On the line side, a receiver pushes finished bytes into the receive queue. A transmitter takes bytes from the head of the transmit queue with a pop strobe. Receive flow control works through two marks. Once the receive level has reached the high mark, the next processor read that leaves the level below the low mark queues a resume code (0x11). That code goes to the transmitter ahead of any queued data. A disconnect input detaches the processor from both queues. While it is high, reads return zero and writes stall.

Top module: `uart_data_port`

## Requirements
- R1: After reset, status is 0x80, the read data is 0x00, tx_valid is low, and irq is low when the mask is zero.
- R2: Received bytes are read back in arrival order, one per cpu_rd pulse. Status bit 6 (receive data available) is 1 exactly while the receive queue holds at least one byte.
- R3: A read of an empty receive queue returns 0x00 on cpu_rdata in the cycle after the read.
- R4: An accepted write appends cpu_wdata to the transmit queue. Status bit 7 (room to transmit) is 1 exactly while the transmit queue is not full. A write to a full queue raises cpu_stall in the same cycle and is not taken.
- R5: irq is 1 exactly when status AND irq_mask is non-zero, using bit 7, bit 6 and bit 2.
- R6: When the receive level has reached XON_HIGH since the last resume code, a processor read that leaves fewer than XON_LOW bytes queues 0x11. The transmitter receives that 0x11 before any queued transmit byte.
- R7: While line_disc is high, a read returns 0x00 and leaves the receive queue and status unchanged. A write raises cpu_stall and adds nothing to the transmit queue.
- R8: A receive push to a full queue drops the byte and sets status bit 2 (overrun). The bit stays set until the next connected processor read clears it.
- R9: A receive push and a processor read in the same cycle leave the receive level unchanged. The read returns the old head byte.
- R10: tx_valid is 1 while a resume code or a transmit byte is pending. tx_byte shows the next byte. Each tx_pop while tx_valid is high consumes exactly that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Data register read strobe |
| cpu_wr | input | 1 | Data register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after cpu_rd |
| cpu_stall | output | 1 | Write not accepted this cycle |
| irq_mask | input | 8 | Per-bit enable of status flags onto irq |
| status | output | 8 | Bit 7 room to transmit, bit 6 data received, bit 2 overrun |
| irq | output | 1 | Interrupt request |
| line_disc | input | 1 | Detaches the processor from the queues |
| rx_push | input | 1 | Receiver byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_pop | input | 1 | Transmitter takes the offered byte |

## Verification
The assertions assume single-cycle strobes that are sampled only at the clock edge. They also assume that the transmitter raises tx_pop only while tx_valid is high, and that a stalled writer holds its request rather than retrying on its own. The stimulus drives every strobe for exactly one cycle, starting from the falling edge. It pops the transmit side only after it has seen tx_valid. It never combines a receive overrun with a read in the same cycle. Simultaneous push and read are applied only at levels away from both flow-control marks, so the resume-code rule stays unambiguous.

// File: rtl/uart_port_pkg.sv
// Shared constants for the buffered serial data port.
// Assumes an 8-bit processor data bus.
package uart_port_pkg;
    localparam int ST_TX_ROOM = 7;
    localparam int ST_RX_DATA = 6;
    localparam int ST_OVERRUN = 2;
    localparam logic [7:0] RESUME_CODE = 8'h11;
endpackage

// File: rtl/byte_ring.sv
// Circular byte queue with an insert index and a fill count; the head entry
// sits at insert index minus fill. A push to a full queue and a pop from an
// empty queue are ignored. Assumes AW >= 1.
module byte_ring #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [AW:0]   count,
    output logic [AW:0]   count_nx,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];

    logic [7:0]    store [DEPTH];
    logic [AW-1:0] ins_idx;
    logic          do_push;
    logic          do_pop;

    // Derive accepted operations and the head pointer.
    always_comb begin
        full     = (count == DEPTH_C);
        empty    = (count == '0);
        do_push  = push && !full;
        do_pop   = pop && !empty;
        head     = store[ins_idx - count[AW-1:0]];
        count_nx = count + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
    end

    // Write accepted bytes into storage.
    always_ff @(posedge clk) begin
        if (do_push) store[ins_idx] <= din;
    end

    // Advance the insert index and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_idx <= '0;
            count   <= '0;
        end else begin
            if (do_push) ins_idx <= ins_idx + 1'b1;
            count <= count_nx;
        end
    end
endmodule

// File: rtl/resume_ctrl.sv
// Receive flow control: arms once the receive level reaches HIGH, and queues
// a resume code when a processor pop leaves the level below LOW.
// Assumes LOW < HIGH <= queue depth.
module resume_ctrl #(
    parameter int AW   = 8,
    parameter int LOW  = 16,
    parameter int HIGH = 192
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [AW:0] rx_count,
    input  logic [AW:0] rx_count_nx,
    input  logic        cpu_pop,
    input  logic        code_taken,
    output logic        pending
);
    localparam logic [AW:0] LOW_C  = LOW[AW:0];
    localparam logic [AW:0] HIGH_C = HIGH[AW:0];

    logic armed;
    logic reached;

    // Level at or above the high mark in this cycle.
    always_comb reached = (rx_count >= HIGH_C);

    // Track the arming state and the pending resume code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            pending <= 1'b0;
        end else begin
            if (cpu_pop && (armed || reached) && (rx_count_nx < LOW_C)) begin
                pending <= 1'b1;
                armed   <= 1'b0;
            end else begin
                armed <= armed | reached;
                if (code_taken) pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_data_port.sv
// Processor-facing serial data register with a receive and a transmit queue,
// status flags, a masked interrupt and automatic resume-code insertion.
// Assumes single-cycle strobes and tx_pop only while tx_valid is high.
module uart_data_port #(
    parameter int DEPTH_LOG2 = 8,
    parameter int XON_LOW    = 16,
    parameter int XON_HIGH   = 192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    output logic       cpu_stall,
    input  logic [7:0] irq_mask,
    output logic [7:0] status,
    output logic       irq,
    input  logic       line_disc,
    input  logic       rx_push,
    input  logic [7:0] rx_byte,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       tx_pop
);
    import uart_port_pkg::*;

    localparam int AW = DEPTH_LOG2;
    localparam logic [AW:0] DEPTH_C = (1 << AW);

    logic          rd_ok, wr_ok, tx_fifo_pop, code_taken;
    logic [7:0]    rx_head, tx_head;
    logic [AW:0]   rx_cnt, rx_cnt_nx, tx_cnt, tx_cnt_nx;
    logic          rx_full, rx_empty, tx_full, tx_empty;
    logic          resume_pending;
    logic          f_room, f_data, f_ovr;

    // Processor access qualification and line-side pop steering.
    always_comb begin
        rd_ok       = cpu_rd && !line_disc;
        wr_ok       = cpu_wr && !line_disc && !tx_full;
        cpu_stall   = cpu_wr && !wr_ok;
        code_taken  = tx_pop && resume_pending;
        tx_fifo_pop = tx_pop && !resume_pending;
    end

    byte_ring #(.AW(AW)) i_rx_ring (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte), .pop(rd_ok),
        .head(rx_head), .count(rx_cnt), .count_nx(rx_cnt_nx),
        .full(rx_full), .empty(rx_empty)
    );

    byte_ring #(.AW(AW)) i_tx_ring (
        .clk(clk), .rst_n(rst_n), .push(wr_ok), .din(cpu_wdata), .pop(tx_fifo_pop),
        .head(tx_head), .count(tx_cnt), .count_nx(tx_cnt_nx),
        .full(tx_full), .empty(tx_empty)
    );

    resume_ctrl #(.AW(AW), .LOW(XON_LOW), .HIGH(XON_HIGH)) i_resume (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_cnt), .rx_count_nx(rx_cnt_nx),
        .cpu_pop(rd_ok && !rx_empty), .code_taken(code_taken),
        .pending(resume_pending)
    );

    // Capture read data on every processor read.
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_rdata <= 8'h00;
        else if (cpu_rd) cpu_rdata <= (rd_ok && !rx_empty) ? rx_head : 8'h00;
    end

    // Recompute the status flags on the accesses that move each queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_room <= 1'b1;
            f_data <= 1'b0;
            f_ovr  <= 1'b0;
        end else begin
            if (rd_ok || rx_push)           f_data <= (rx_cnt_nx != '0);
            if (wr_ok || tx_fifo_pop)       f_room <= (tx_cnt_nx != DEPTH_C);
            if (rx_push && rx_full)         f_ovr  <= 1'b1;
            else if (rd_ok)                 f_ovr  <= 1'b0;
        end
    end

    // Assemble status, interrupt and transmitter offer.
    always_comb begin
        status             = 8'h00;
        status[ST_TX_ROOM] = f_room;
        status[ST_RX_DATA] = f_data;
        status[ST_OVERRUN] = f_ovr;
        irq                = |(status & irq_mask);
        tx_valid           = resume_pending || !tx_empty;
        tx_byte            = resume_pending ? RESUME_CODE : tx_head;
    end
endmodule

// File: rtl/uart_data_port_chk.sv
// Temporal checks on the port-level behaviour of uart_data_port.
module uart_data_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_rd,
    input logic       cpu_wr,
    input logic       cpu_stall,
    input logic [7:0] cpu_rdata,
    input logic       line_disc,
    input logic [7:0] status,
    input logic       rx_push,
    input logic       tx_valid,
    input logic       tx_pop
);
    // R3: reading with no data available yields zero next cycle.
    assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !line_disc && !status[6]) |=> (cpu_rdata == 8'h00));

    // R7: a detached read yields zero next cycle.
    assert_detached_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && line_disc) |=> (cpu_rdata == 8'h00));

    // R4: a write without room stalls.
    assert_full_write_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !status[7]) |-> cpu_stall);

    // R2: data-available only rises after a receive push.
    assert_data_flag_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> $past(rx_push));

    // R8: overrun stays set until a processor read.
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !cpu_rd) |=> status[2]);

    // R10: an offered byte stays offered until taken.
    assert_offer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_pop) |=> tx_valid);
endmodule

bind uart_data_port uart_data_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_stall(cpu_stall), .cpu_rdata(cpu_rdata), .line_disc(line_disc),
    .status(status), .rx_push(rx_push), .tx_valid(tx_valid), .tx_pop(tx_pop)
);

// File: tb/test_uart_data_port.sv
module test_uart_data_port;
    localparam int AW = 3;
    localparam int D  = 1 << AW;
    localparam int LO = 2;
    localparam int HI = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_rd = 0, cpu_wr = 0, line_disc = 0, rx_push = 0, tx_pop = 0;
    logic [7:0] cpu_wdata = 0, irq_mask = 0, rx_byte = 0;
    logic [7:0] cpu_rdata, status, tx_byte;
    logic cpu_stall, irq, tx_valid;

    int nchk = 0, nerr = 0;
    int rxq[D]; int rxn = 0;
    int txq[D]; int txn = 0;
    bit ovr = 0, armed = 0, xp = 0;

    always #2 clk = ~clk;

    uart_data_port #(.DEPTH_LOG2(AW), .XON_LOW(LO), .XON_HIGH(HI)) i_uart_data_port (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .irq_mask(irq_mask), .status(status), .irq(irq), .line_disc(line_disc),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_pop(tx_pop)
    );

    task automatic tick; @(posedge clk); @(negedge clk); endtask

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_status();
        return ((txn != D) ? 8'h80 : 0) | ((rxn != 0) ? 8'h40 : 0) | (ovr ? 8'h04 : 0);
    endfunction

    task automatic rx_put(int b);
        rx_push = 1; rx_byte = 8'(b); tick; rx_push = 0;
        if (rxn < D) begin rxq[rxn] = b; rxn++; if (rxn >= HI) armed = 1; end
        else ovr = 1;
    endtask

    task automatic cpu_read(string req);
        int e;
        cpu_rd = 1; tick; cpu_rd = 0;
        e = 0;
        if (!line_disc) begin
            ovr = 0;
            if (rxn > 0) begin
                e = rxq[0];
                for (int i = 1; i < D; i++) rxq[i-1] = rxq[i];
                rxn--;
                if (armed && rxn < LO) begin xp = 1; armed = 0; end
            end
        end
        check(req, cpu_rdata, e);
        check(req, status, exp_status());
    endtask

    task automatic cpu_write(string req, int b);
        bit acc;
        cpu_wr = 1; cpu_wdata = 8'(b); #1;
        acc = !line_disc && (txn < D);
        check(req, cpu_stall, !acc);
        tick; cpu_wr = 0;
        if (acc) begin txq[txn] = b; txn++; end
        check(req, status, exp_status());
    endtask

    task automatic tx_take(string req);
        check(req, tx_valid, (xp || txn > 0));
        if (tx_valid) begin
            if (xp) begin check(req, tx_byte, 8'h11); xp = 0; end
            else begin
                check(req, tx_byte, txq[0]);
                for (int i = 1; i < D; i++) txq[i-1] = txq[i];
                txn--;
            end
            tx_pop = 1; tick; tx_pop = 0;
        end
    endtask

    task automatic drain_tx(string req);
        while (xp || txn > 0) tx_take(req);
        check(req, tx_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        @(negedge clk); tick; rst_n = 1; tick;
        // R1 reset state
        check("R1 status", status, 8'h80);
        check("R1 rdata", cpu_rdata, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 irq", irq, 0);

        // R2 R3 R6: every receive level, read one past empty
        for (int n = 0; n <= D; n++) begin
            for (int k = 0; k < n; k++) rx_put(n * 16 + k);
            check("R2 level flag", status, exp_status());
            for (int k = 0; k <= n; k++) cpu_read((k == n) ? "R3 empty read" : "R2 order");
            drain_tx("R6 resume code");
        end

        // R8 overrun: one push beyond full
        for (int k = 0; k <= D; k++) rx_put(8'hA0 + k);
        check("R8 overrun flag", status, exp_status());
        tick;
        check("R8 sticky", status[2], 1);
        for (int k = 0; k <= D; k++) cpu_read("R8 dropped byte");
        check("R8 cleared", status[2], 0);
        drain_tx("R6 after overrun");

        // R4 R10: every transmit level, stall at full, order out
        for (int n = 1; n <= D; n++) begin
            for (int k = 0; k < n; k++) cpu_write("R4 push", 8'h30 + n * 8 + k);
            if (n == D) begin
                cpu_write("R4 stall full", 8'hEE);
                tx_take("R10 free one");
                cpu_write("R4 after space", 8'hEF);
            end
            drain_tx("R10 order");
        end

        // R6: resume code jumps ahead of queued transmit data
        cpu_write("R6 queue", 8'h55);
        cpu_write("R6 queue", 8'h66);
        for (int k = 0; k < HI; k++) rx_put(k + 1);
        for (int k = 0; k < HI; k++) cpu_read("R6 drain rx");
        check("R6 code first", tx_byte, 8'h11);
        drain_tx("R6 ahead");

        // R5: mask sweep over several status states
        for (int s = 0; s < 3; s++) begin
            if (s == 1) rx_put(8'h42);
            if (s == 2) for (int k = 0; k < D; k++) cpu_write("R5 fill", k);
            for (int m = 0; m < 256; m += 4) begin
                irq_mask = 8'(m); #1;
                check("R5 irq", irq, ((exp_status() & m) != 0) ? 1 : 0);
            end
        end
        irq_mask = 0;
        drain_tx("R5 cleanup");

        // R7: detached read and write
        line_disc = 1;
        cpu_read("R7 detached read");
        cpu_write("R7 detached write", 8'h99);
        check("R7 no tx", tx_valid, 0);
        line_disc = 0;
        cpu_read("R7 data kept");

        // R9: push and read in the same cycle
        rx_put(8'h71); rx_put(8'h72); rx_put(8'h73);
        rx_push = 1; rx_byte = 8'h74; cpu_rd = 1; tick; rx_push = 0; cpu_rd = 0;
        check("R9 old head", cpu_rdata, 8'h71);
        for (int i = 1; i < D; i++) rxq[i-1] = rxq[i];
        rxq[2] = 8'h74;
        check("R9 flag", status, exp_status());
        for (int k = 0; k < 4; k++) cpu_read("R9 level kept");
        drain_tx("R9 cleanup");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule